// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Stack

This block keeps the instruction address of a small 16-bit processor whose program space holds 4096 words. On every enabled cycle it advances the address by one, loads an absolute target, takes or skips a flag-conditioned relative branch, enters a subroutine or leaves one. Return addresses go into a private last-in-first-out store inside the block. Software cannot read or write that store except by calling and returning. The decoder outside the block raises one or more request lines together with the clock enable and supplies the target, the offset, the condition code and the status flags. The block drives the current address and two one-cycle error pulses.

Stack occupancy is tracked by a three-state machine. `ST_EMPTY` holds no return address. `ST_HOLDING` holds between one and DEPTH-1 addresses. `ST_FULL` holds DEPTH addresses. A push moves `ST_EMPTY` to `ST_HOLDING`. A push moves `ST_HOLDING` to `ST_FULL` when the last free slot is filled. A pop moves `ST_HOLDING` to `ST_EMPTY` when the last entry is removed. A pop moves `ST_FULL` to `ST_HOLDING`. A call rejected in `ST_FULL` and a return rejected in `ST_EMPTY` leave the state unchanged.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x000, both error pulses are 0 and the stack is empty. A return issued right after reset is therefore an underflow.
- R2: When `en` is high and no request line is high, `pc` becomes `pc`+1 at the clock edge. When `en` is low, `pc`, the stack and the state do not change, and both error pulses are 0 after that edge.
- R3: A jump request loads `target` into `pc`.
- R4: A branch request tests the flag selected by `cond`. The flag bits are `flags[0]`=Z, `[1]`=C, `[2]`=O, `[3]`=N and `[4]`=P. The codes are 000 Z set, 001 Z clear, 010 C set, 011 C clear, 100 O set, 101 O clear, 110 N set and 111 P set. When the test passes, `pc` becomes `pc` plus the sign-extended 9-bit `offset`. When it fails, `pc` becomes `pc`+1.
- R5: A call that finds a free slot stores `pc`+1 on the stack and loads `target` into `pc`.
- R6: A return that finds a stored address loads the most recently stored address into `pc` and removes it. Nested returns come back in reverse order of the calls.
- R7: A call made while DEPTH addresses are stored sets `stk_ovf` for exactly one cycle. The stack is left unchanged and `pc` becomes `pc`+1. `stk_ovf` and `stk_unf` are never high together.
- R8: A return made with an empty stack sets `stk_unf` for exactly one cycle and `pc` becomes `pc`+1.
- R9: When several request lines are high, only one takes effect, in this order of precedence: call, then return, then jump, then branch.
- R10: All address arithmetic wraps modulo 4096, both the increment and the relative branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance enable; one operation per enabled edge |
| do_call | input | 1 | Subroutine entry request |
| do_ret | input | 1 | Subroutine exit request |
| do_jump | input | 1 | Absolute jump request |
| do_branch | input | 1 | Conditional relative branch request |
| target | input | 12 | Absolute address for jump and call |
| offset | input | 9 | Signed branch displacement |
| cond | input | 3 | Branch condition code |
| flags | input | 5 | Status flags {P,N,O,C,Z} |
| pc | output | 12 | Current instruction address |
| stk_ovf | output | 1 | One-cycle pulse: call refused, stack full |
| stk_unf | output | 1 | One-cycle pulse: return refused, stack empty |

## Verification
The assertions assume two things about the inputs. Request lines matter only on edges where `en` is high. `target`, `offset`, `cond` and `flags` hold known values whenever a request line they feed is high. The bench changes every input only on the falling clock edge. It raises `en` for a single edge per operation and returns the request lines to zero afterwards. This way each rising edge sees exactly one intended operation on settled inputs. Reset is asserted from time zero, so the reset-state property starts from defined values.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_HOLDING = 2'd1,
        ST_FULL    = 2'd2
    } stk_state_e;

    typedef enum logic [2:0] {
        CC_ZERO     = 3'b000,
        CC_NONZERO  = 3'b001,
        CC_CARRY    = 3'b010,
        CC_NOCARRY  = 3'b011,
        CC_OVFL     = 3'b100,
        CC_NOOVFL   = 3'b101,
        CC_NEG      = 3'b110,
        CC_POS      = 3'b111
    } cond_e;

    localparam int FLG_Z = 0;
    localparam int FLG_C = 1;
    localparam int FLG_O = 2;
    localparam int FLG_N = 3;
    localparam int FLG_P = 4;
    localparam int FLG_W = 5;

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
    import pcseq_pkg::*;
(
    input  logic [2:0]       cond,
    input  logic [FLG_W-1:0] flags,
    output logic             take
);

    always_comb begin
        unique case (cond_e'(cond))
            CC_ZERO:    take =  flags[FLG_Z];
            CC_NONZERO: take = ~flags[FLG_Z];
            CC_CARRY:   take =  flags[FLG_C];
            CC_NOCARRY: take = ~flags[FLG_C];
            CC_OVFL:    take =  flags[FLG_O];
            CC_NOOVFL:  take = ~flags[FLG_O];
            CC_NEG:     take =  flags[FLG_N];
            CC_POS:     take =  flags[FLG_P];
            default:    take = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int DEPTH = 8,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout,
    output logic          at_last,
    output logic          at_first
);

    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SP_W-1:0]  sp;
    logic [AW-1:0]    mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_idx   = IDX_W'(sp);
    assign rd_idx   = IDX_W'(sp - SP_W'(1));
    assign dout     = (sp != '0) ? mem[rd_idx] : '0;
    assign at_last  = (sp == SP_W'(DEPTH - 1));
    assign at_first = (sp == SP_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push) begin
            sp <= sp + SP_W'(1);
        end else if (pop) begin
            sp <= sp - SP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx] <= din;
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int OFF_W = 9,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             do_call,
    input  logic             do_ret,
    input  logic             do_jump,
    input  logic             do_branch,
    input  logic [PC_W-1:0]  target,
    input  logic [OFF_W-1:0] offset,
    input  logic [2:0]       cond,
    input  logic [FLG_W-1:0] flags,
    output logic [PC_W-1:0]  pc,
    output logic             stk_ovf,
    output logic             stk_unf
);

    localparam int EXT_W = PC_W - OFF_W;

    stk_state_e      state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d, pc_inc, off_ext, stk_top;
    logic            take, at_last, at_first;
    logic            sel_call, sel_ret, sel_jump, sel_br;
    logic            push, pop;

    pcseq_cond u_cond (
        .cond  (cond),
        .flags (flags),
        .take  (take)
    );

    pcseq_stack #(.DEPTH(DEPTH), .AW(PC_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .din      (pc_inc),
        .dout     (stk_top),
        .at_last  (at_last),
        .at_first (at_first)
    );

    // precedence: call, return, jump, branch, increment
    assign sel_call = en & do_call;
    assign sel_ret  = en & ~do_call & do_ret;
    assign sel_jump = en & ~do_call & ~do_ret & do_jump;
    assign sel_br   = en & ~do_call & ~do_ret & ~do_jump & do_branch;
    assign push     = sel_call & (state_q != ST_FULL);
    assign pop      = sel_ret  & (state_q != ST_EMPTY);

    assign pc_inc  = pc_q + PC_W'(1);
    assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};

    always_comb begin
        pc_d = pc_q;
        if (en) begin
            pc_d = pc_inc;
            if (push) begin
                pc_d = target;
            end else if (pop) begin
                pc_d = stk_top;
            end else if (sel_jump) begin
                pc_d = target;
            end else if (sel_br && take) begin
                pc_d = pc_q + off_ext;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) state_d = ST_HOLDING;
            end
            ST_HOLDING: begin
                if (push && at_last)      state_d = ST_FULL;
                else if (pop && at_first) state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (pop) state_d = ST_HOLDING;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            stk_ovf <= 1'b0;
            stk_unf <= 1'b0;
        end else begin
            pc_q    <= pc_d;
            stk_ovf <= sel_call & (state_q == ST_FULL);
            stk_unf <= sel_ret  & (state_q == ST_EMPTY);
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            do_call,
    input logic            do_ret,
    input logic            do_jump,
    input logic            do_branch,
    input logic [PC_W-1:0] target,
    input logic [PC_W-1:0] pc,
    input logic            stk_ovf,
    input logic            stk_unf
);

    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |-> (pc == '0 && !stk_ovf && !stk_unf));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(pc) && !stk_ovf && !stk_unf));

    assert_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !do_call && !do_ret && !do_jump && !do_branch)
        |=> (pc == PC_W'($past(pc) + 1'b1)));

    assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && do_jump && !do_call && !do_ret) |=> (pc == $past(target)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |-> $past(en && do_call));

    assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_ovf && stk_unf));

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf |-> $past(en && do_ret && !do_call));

endmodule

bind pc_sequencer pcseq_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .do_call   (do_call),
    .do_ret    (do_ret),
    .do_jump   (do_jump),
    .do_branch (do_branch),
    .target    (target),
    .pc        (pc),
    .stk_ovf   (stk_ovf),
    .stk_unf   (stk_unf)
);

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        do_call = 1'b0, do_ret = 1'b0, do_jump = 1'b0, do_branch = 1'b0;
    logic [11:0] target = '0;
    logic [8:0]  offset = '0;
    logic [2:0]  cond = '0;
    logic [4:0]  flags = '0;
    logic [11:0] pc;
    logic        stk_ovf, stk_unf;

    int checks = 0;
    int errors = 0;
    logic [11:0] cur;
    logic [11:0] saved [8];

    always #4 clk = ~clk;

    pc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .do_call(do_call), .do_ret(do_ret), .do_jump(do_jump), .do_branch(do_branch),
        .target(target), .offset(offset), .cond(cond), .flags(flags),
        .pc(pc), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    // branch vectors from pc 0x100: cond, flags {P,N,O,C,Z}, offset, expected pc (R4)
    typedef struct packed {
        logic [2:0]  cc;
        logic [4:0]  fl;
        logic [8:0]  of;
        logic [11:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'b000, 5'b00001, 9'h00A, 12'h10A},
        '{3'b000, 5'b00000, 9'h00A, 12'h101},
        '{3'b001, 5'b00000, 9'h1FF, 12'h0FF},
        '{3'b010, 5'b00010, 9'h064, 12'h164},
        '{3'b011, 5'b00010, 9'h1FC, 12'h101},
        '{3'b100, 5'b00100, 9'h068, 12'h168},
        '{3'b101, 5'b00000, 9'h1F8, 12'h0F8},
        '{3'b110, 5'b01000, 9'h005, 12'h105},
        '{3'b111, 5'b10000, 9'h100, 12'h000},
        '{3'b111, 5'b01000, 9'h0FF, 12'h101}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, hold through one rising edge, release at the next falling edge
    task automatic op(input logic c, input logic r, input logic j, input logic b,
                      input logic [11:0] tg, input logic [8:0] of,
                      input logic [2:0] cc, input logic [4:0] fl);
        en = 1'b1; do_call = c; do_ret = r; do_jump = j; do_branch = b;
        target = tg; offset = of; cond = cc; flags = fl;
        @(negedge clk);
        en = 1'b0; do_call = 1'b0; do_ret = 1'b0; do_jump = 1'b0; do_branch = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pc", pc, 0);
        check("R1 reset ovf", stk_ovf, 0);
        check("R1 reset unf", stk_unf, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: enable low holds
        repeat (3) @(negedge clk);
        check("R2 hold", pc, 0);
        op(0, 0, 0, 0, 12'h0, 9'h0, 3'b0, 5'b0);
        check("R2 increment", pc, 1);

        // R3: jump
        op(0, 0, 1, 0, 12'h123, 9'h0, 3'b0, 5'b0);
        check("R3 jump", pc, 12'h123);

        // R4: branch table
        for (int i = 0; i < 10; i++) begin
            op(0, 0, 1, 0, 12'h100, 9'h0, 3'b0, 5'b0);
            op(0, 0, 0, 1, 12'h0, VECS[i].of, VECS[i].cc, VECS[i].fl);
            check($sformatf("R4 branch vector %0d", i), pc, VECS[i].exp);
        end

        // R10: wrap on increment and on backward branch
        op(0, 0, 1, 0, 12'hFFF, 9'h0, 3'b0, 5'b0);
        op(0, 0, 0, 0, 12'h0, 9'h0, 3'b0, 5'b0);
        check("R10 increment wrap", pc, 0);
        op(0, 0, 1, 0, 12'h002, 9'h0, 3'b0, 5'b0);
        op(0, 0, 0, 1, 12'h0, 9'h1FC, 3'b000, 5'b00001);
        check("R10 branch wrap", pc, 12'hFFE);

        // R5: eight nested calls
        op(0, 0, 1, 0, 12'h010, 9'h0, 3'b0, 5'b0);
        cur = 12'h010;
        for (int i = 0; i < 8; i++) begin
            saved[i] = cur + 12'd1;
            cur = 12'h200 + 12'(i * 16);
            op(1, 0, 0, 0, cur, 9'h0, 3'b0, 5'b0);
            check($sformatf("R5 call depth %0d", i + 1), pc, cur);
            check("R7 no overflow below depth", stk_ovf, 0);
        end

        // R7: ninth call refused
        op(1, 0, 0, 0, 12'h7FF, 9'h0, 3'b0, 5'b0);
        cur = cur + 12'd1;
        check("R7 overflow pulse", stk_ovf, 1);
        check("R7 overflow pc", pc, cur);
        op(0, 0, 0, 0, 12'h0, 9'h0, 3'b0, 5'b0);
        cur = cur + 12'd1;
        check("R7 pulse one cycle", stk_ovf, 0);
        check("R2 increment after overflow", pc, cur);

        // R6: returns in reverse order; stack unchanged by refused call
        for (int i = 7; i >= 0; i--) begin
            op(0, 1, 0, 0, 12'h0, 9'h0, 3'b0, 5'b0);
            check($sformatf("R6 return level %0d", i), pc, saved[i]);
            check("R8 no underflow while holding", stk_unf, 0);
            cur = saved[i];
        end

        // R8: return on empty
        op(0, 1, 0, 0, 12'h0, 9'h0, 3'b0, 5'b0);
        cur = cur + 12'd1;
        check("R8 underflow pulse", stk_unf, 1);
        check("R8 underflow pc", pc, cur);
        @(negedge clk);
        check("R8 pulse one cycle", stk_unf, 0);

        // R9: precedence
        op(1, 1, 1, 1, 12'h345, 9'h010, 3'b000, 5'b00001);
        check("R9 call wins", pc, 12'h345);
        op(0, 1, 1, 1, 12'h0AA, 9'h010, 3'b000, 5'b00001);
        check("R9 return beats jump", pc, cur + 12'd1);
        op(0, 0, 1, 1, 12'h0BB, 9'h010, 3'b000, 5'b00001);
        check("R9 jump beats branch", pc, 12'h0BB);

        // R1: reset empties the stack
        op(1, 0, 0, 0, 12'h400, 9'h0, 3'b0, 5'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run pc", pc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        op(0, 1, 0, 0, 12'h0, 9'h0, 3'b0, 5'b0);
        check("R1 stack empty after reset", stk_unf, 1);
        check("R1 pc after empty return", pc, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule